// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block moves a parallel word between an A side and a B side with two fully independent lanes: lane AB carries `a_in` to `b_out`, lane BA carries `b_in` to `a_out`. Each lane has one storage word and four controls:

- a pass enable (`*_le`, active high);
- a capture strobe (`*_strobe`);
- a capture enable (`*_ce_n`, active low);
- a drive enable (`*_oe_n`, active low).

While the pass enable is high, the lane is transparent. The output follows the source word, and the storage word tracks it on every clock edge. While the pass enable is low, the lane holds its word. It loads a new word only on a rising edge of the capture strobe, and only if the capture enable is low at that edge. The strobe and all controls are synchronous to `clk` and are sampled on its rising edge. A rising strobe edge is a sample at 1 that follows a sample at 0 taken while the lane was already latched.

Each lane runs a small sequencer with three named states:

| State | Meaning |
|---|---|
| `ST_PASS` | Transparent mode. |
| `ST_ARMED` | Latched, and the strobe was last seen low. |
| `ST_SPENT` | Latched, and the strobe was last seen high. |

The sequencer has these transitions:

| Transition | Condition |
|---|---|
| Any state to `ST_PASS` | Pass enable high. |
| `ST_PASS` to `ST_ARMED` | Pass enable low and strobe low. |
| `ST_PASS` to `ST_SPENT` | Pass enable low and strobe high. No capture. |
| `ST_ARMED` to `ST_SPENT` | Strobe high. Capture happens if the capture enable is low. |
| `ST_SPENT` to `ST_ARMED` | Strobe low. |

The destination bus is modelled as a data port and a separate drive-enable output, rather than a tristate pin.

Top module: `bus_xcvr_dual`

## Requirements
- R1: Both lanes carry a W-bit word, W = 18 by default, without inversion: a driven output bit equals the corresponding source bit of the passed or stored word.
- R2: While `ab_le` = 1 and `ab_oe_n` = 0, `b_out` equals `a_in` in the same cycle, with no clock delay.
- R3: While `ab_le` = 0 and the strobe shows no rising edge, the stored word and the driven `b_out` stay unchanged, whatever `a_in` does.
- R4: With `ab_le` = 0 and the lane in `ST_ARMED`, a clock edge that samples `ab_strobe` = 1 and `ab_ce_n` = 0 stores `a_in`. The new word appears on `b_out` right after that edge.
- R5: A rising strobe edge sampled with `ab_ce_n` = 1 stores nothing. The edge is also consumed: lowering `ab_ce_n` while the strobe stays high stores nothing.
- R6: When `ab_le` falls, the lane keeps the word sampled at the last clock edge at which `ab_le` was 1.
- R7: `b_oe` = 1 exactly when `ab_oe_n` = 0. While `b_oe` = 0, `b_out` is all zeros, and the stored word is unaffected.
- R8: Reset (`rst_n` = 0, asynchronous) clears both stored words to zero and puts both sequencers in `ST_PASS`.
- R9: Lane BA obeys R2 to R7 with `ba_le`, `ba_strobe`, `ba_ce_n` and `ba_oe_n`, from `b_in` to `a_out`/`a_oe`. Neither lane's controls or data affect the other lane.
- R10: If the strobe is first sampled high at the same edge at which `ab_le` is first sampled 0, that edge is not a capture edge. The lane holds the passed word until the strobe is seen low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Word arriving from the A bus |
| a_out | output | W | Word driven toward the A bus (zero when not driving) |
| a_oe | output | 1 | A-side drive enable, active high |
| b_in | input | W | Word arriving from the B bus |
| b_out | output | W | Word driven toward the B bus (zero when not driving) |
| b_oe | output | 1 | B-side drive enable, active high |
| ab_le | input | 1 | Lane AB pass enable, active high |
| ab_strobe | input | 1 | Lane AB capture strobe |
| ab_ce_n | input | 1 | Lane AB capture enable, active low |
| ab_oe_n | input | 1 | Lane AB drive enable, active low |
| ba_le | input | 1 | Lane BA pass enable, active high |
| ba_strobe | input | 1 | Lane BA capture strobe |
| ba_ce_n | input | 1 | Lane BA capture enable, active low |
| ba_oe_n | input | 1 | Lane BA drive enable, active low |

## Verification
The hardest situation to reach from the ports is the consumed strobe edge. In that situation the strobe rose while capture was disabled, and the capture enable is then lowered while the strobe stays high. The same applies to a strobe that rises in the very cycle the lane leaves transparent mode.

Random stimulus rarely lines up those orderings, so directed sequences build them step by step. Each sequence is followed by a change of the source word, so that any unwanted load becomes visible. Random phases with independent per-lane controls then check that each lane's output matches a bench model of the three-state sequencer.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    // Per-lane sequencer state
    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SPENT = 2'd2
    } lane_state_e;

    localparam int unsigned LANES = 2;
endpackage

// File: rtl/xcvr_seq.sv
module xcvr_seq
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le,
    input  logic strobe,
    input  logic ce_n,
    output logic cap
);
    lane_state_e state_q;
    lane_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (le) begin
            state_d = ST_PASS;
        end else begin
            unique case (state_q)
                ST_PASS:  state_d = strobe ? ST_SPENT : ST_ARMED;
                ST_ARMED: state_d = strobe ? ST_SPENT : ST_ARMED;
                ST_SPENT: state_d = strobe ? ST_SPENT : ST_ARMED;
                default:  state_d = ST_PASS;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    // Outputs: capture pulse on an armed rising strobe with enable low
    always_comb begin
        cap = 1'b0;
        unique case (state_q)
            ST_ARMED: cap = !le && strobe && !ce_n;
            ST_PASS,
            ST_SPENT: cap = 1'b0;
            default:  cap = 1'b0;
        endcase
    end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         cap,
    input  logic         oe_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);
    logic [W-1:0] word_q;
    logic [W-1:0] view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         word_q <= '0;
        else if (le || cap) word_q <= din;
    end

    always_comb begin
        view  = le ? din : word_q;
        drive = !oe_n;
        dout  = drive ? view : '0;
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         strobe,
    input  logic         ce_n,
    input  logic         oe_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);
    logic cap;

    xcvr_seq seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .le     (le),
        .strobe (strobe),
        .ce_n   (ce_n),
        .cap    (cap)
    );

    xcvr_store #(.W(W)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le),
        .cap   (cap),
        .oe_n  (oe_n),
        .din   (din),
        .dout  (dout),
        .drive (drive)
    );
endmodule

// File: rtl/bus_xcvr_dual.sv
module bus_xcvr_dual
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_le,
    input  logic         ab_strobe,
    input  logic         ab_ce_n,
    input  logic         ab_oe_n,
    input  logic         ba_le,
    input  logic         ba_strobe,
    input  logic         ba_ce_n,
    input  logic         ba_oe_n
);
    // Lane 0 = A to B, lane 1 = B to A
    logic [W-1:0]     src  [LANES];
    logic [W-1:0]     dst  [LANES];
    logic [LANES-1:0] le_v, stb_v, cen_v, oen_v, drv_v;

    always_comb begin
        src[0] = a_in;  src[1] = b_in;
        le_v   = {ba_le, ab_le};
        stb_v  = {ba_strobe, ab_strobe};
        cen_v  = {ba_ce_n, ab_ce_n};
        oen_v  = {ba_oe_n, ab_oe_n};
        b_out  = dst[0];
        b_oe   = drv_v[0];
        a_out  = dst[1];
        a_oe   = drv_v[1];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        xcvr_lane #(.W(W)) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .le     (le_v[i]),
            .strobe (stb_v[i]),
            .ce_n   (cen_v[i]),
            .oe_n   (oen_v[i]),
            .din    (src[i]),
            .dout   (dst[i]),
            .drive  (drv_v[i])
        );
    end
endmodule

// File: rtl/bus_xcvr_dual_chk.sv
module bus_xcvr_dual_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         ab_le,
    input logic         ab_strobe,
    input logic         ab_ce_n,
    input logic         ab_oe_n,
    input logic         ba_le,
    input logic         ba_strobe,
    input logic         ba_ce_n,
    input logic         ba_oe_n
);
    AST_AB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && !ab_oe_n) |-> (b_out == a_in)); // R2

    AST_BA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_le && !ba_oe_n) |-> (a_out == b_in)); // R9

    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ab_le && $past(!ab_le) && !ab_strobe && $past(!ab_strobe)
         && !ab_oe_n && $past(!ab_oe_n)) |-> $stable(b_out)); // R3

    AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ba_le && $past(!ba_le) && !ba_strobe && $past(!ba_strobe)
         && !ba_oe_n && $past(!ba_oe_n)) |-> $stable(a_out)); // R9

    AST_AB_CE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ab_ce_n) && $past(!ab_le) && !ab_le
         && !ab_oe_n && $past(!ab_oe_n)) |-> $stable(b_out)); // R5

    AST_BA_CE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ba_ce_n) && $past(!ba_le) && !ba_le
         && !ba_oe_n && $past(!ba_oe_n)) |-> $stable(a_out)); // R9

    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(!ab_le, 2) && $past(!ab_strobe, 2)
         && $past(!ab_le) && $past(ab_strobe) && $past(!ab_ce_n)
         && !ab_le && !ab_oe_n) |-> (b_out == $past(a_in))); // R4

    AST_B_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe |-> (b_out == '0)); // R7

    AST_A_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !a_oe |-> (a_out == '0)); // R7
endmodule

bind bus_xcvr_dual bus_xcvr_dual_chk #(.W(W)) chk_i (.*);

// File: tb/bus_xcvr_dual_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr_dual_tb_top;
    localparam int unsigned W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_le = 1'b0, ab_strobe = 1'b0, ab_ce_n = 1'b1, ab_oe_n = 1'b0;
    logic         ba_le = 1'b0, ba_strobe = 1'b0, ba_ce_n = 1'b1, ba_oe_n = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Model: per lane stored word and state (0 pass, 1 armed, 2 spent)
    logic [W-1:0] m_word [2];
    int           m_st   [2];

    always #4 clk = ~clk; // 125 MHz

    bus_xcvr_dual #(.W(W)) dut_i (.*);

    function automatic logic [W-1:0] exp_out(int d);
        logic le, oen;
        logic [W-1:0] src;
        le  = (d == 0) ? ab_le : ba_le;
        oen = (d == 0) ? ab_oe_n : ba_oe_n;
        src = (d == 0) ? a_in : b_in;
        if (oen) return '0;
        return le ? src : m_word[d];
    endfunction

    function automatic void model_edge(int d);
        logic le, stb, cen;
        logic [W-1:0] src;
        le  = (d == 0) ? ab_le : ba_le;
        stb = (d == 0) ? ab_strobe : ba_strobe;
        cen = (d == 0) ? ab_ce_n : ba_ce_n;
        src = (d == 0) ? a_in : b_in;
        if (le) begin
            m_word[d] = src;
            m_st[d]   = 0;
        end else if (m_st[d] == 0) begin
            m_st[d] = stb ? 2 : 1;
        end else if (m_st[d] == 1) begin
            if (stb) begin
                if (!cen) m_word[d] = src;
                m_st[d] = 2;
            end
        end else if (!stb) begin
            m_st[d] = 1;
        end
    endfunction

    task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: check at negedge+1, then advance model at posedge
    task automatic step(string tag);
        @(negedge clk);
        #1;
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                m_word[d] = '0;
                m_st[d]   = 0;
            end
        end
        cmp(tag, "b_out", b_out, exp_out(0));
        cmp(tag, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, !ab_oe_n});
        cmp(tag, "a_out", a_out, exp_out(1));
        cmp(tag, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, !ba_oe_n});
        @(posedge clk);
        if (rst_n) begin
            model_edge(0);
            model_edge(1);
        end
        #1;
    endtask

    task automatic set_both(logic le, logic stb, logic cen, logic oen);
        ab_le = le; ab_strobe = stb; ab_ce_n = cen; ab_oe_n = oen;
        ba_le = le; ba_strobe = stb; ba_ce_n = cen; ba_oe_n = oen;
    endtask

    task automatic new_data();
        a_in = W'($urandom);
        b_in = W'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int d = 0; d < 2; d++) begin
            m_word[d] = '0;
            m_st[d]   = 0;
        end
        // R8: reset clears stored words
        a_in = 18'h3ffff; b_in = 18'h2aaaa;
        step("R8");
        step("R8");
        rst_n = 1'b1;
        step("R8");

        // R2: transparent pass-through
        set_both(1, 0, 1, 0);
        for (int i = 0; i < 4; i++) begin new_data(); step("R2"); end
        // R6: le falls, last passed word kept
        set_both(0, 0, 1, 0);
        step("R6");
        new_data(); step("R6");
        // R3: hold with static strobe
        for (int i = 0; i < 4; i++) begin new_data(); step("R3"); end
        ab_strobe = 1; ba_strobe = 1; // high but ce_n = 1 - consumed
        new_data(); step("R5");
        ab_ce_n = 0; ba_ce_n = 0;     // still high: no new edge
        new_data(); step("R5");
        new_data(); step("R5");
        // R4: proper capture
        ab_strobe = 0; ba_strobe = 0;
        new_data(); step("R4");
        ab_strobe = 1; ba_strobe = 1;
        new_data(); step("R4");
        new_data(); step("R4");
        // R10: strobe rises together with le falling
        set_both(1, 0, 0, 0);
        new_data(); step("R10");
        set_both(0, 1, 0, 0);
        step("R10");
        new_data(); step("R10");
        new_data(); step("R10");
        // R7: drive enable toggling on both lanes at once
        for (int i = 0; i < 6; i++) begin
            ab_oe_n = i[0]; ba_oe_n = i[0];
            new_data(); step("R7");
        end
        // R9: lane BA captures while lane AB is transparent, then swapped
        set_both(0, 0, 0, 0); step("R9");
        ab_le = 1; ba_strobe = 1; new_data(); step("R9");
        new_data(); step("R9");
        ab_le = 0; ab_strobe = 0; ba_le = 1; step("R9");
        ab_strobe = 1; new_data(); step("R9");
        new_data(); step("R9");

        // R1: random mix with independent lanes
        for (int i = 0; i < 3000; i++) begin
            ab_le     = ($urandom_range(0, 7) == 0);
            ba_le     = ($urandom_range(0, 7) == 0);
            ab_strobe = 1'($urandom);
            ba_strobe = 1'($urandom);
            ab_ce_n   = 1'($urandom);
            ba_ce_n   = 1'($urandom);
            ab_oe_n   = ($urandom_range(0, 5) == 0);
            ba_oe_n   = ($urandom_range(0, 5) == 0);
            new_data();
            step("R1");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule